// File: doc/BRIEF.md
# DAC Trigger and Waveform Datapath

This block is the digital front end of a single converter channel. A bus-side write puts a 12-bit sample into a holding register, in one of three alignments. With triggering off, the output register simply follows the holding register.

With triggering on, one of eight trigger lines, picked by a select field, starts a transfer. At an accepted trigger the block adds a generator value to the held sample and saturates the sum. The generator value is either zero, masked pseudo-random noise, or a triangle count. Three clock edges later the result lands in the 12-bit output register, and the generator then steps once.

Top module: `dac_wavegen`

## Requirements
- R1: The wave field selects the generator: 00 adds zero, 01 adds masked noise, and both 10 and 11 add the triangle count.
- R2: A write stores a 12-bit value. Format 00 (and 11) takes wr_data[11:0]. Format 01 takes wr_data[15:4]. Format 10 puts wr_data[7:0] into value bits 11:4 and sets bits 3:0 to zero.
- R3: While trig_en is 0, dout takes the holding value on every edge (except a transfer edge). A write sampled at edge N therefore appears on dout after edge N+1.
- R4: A trigger is accepted when trig_en is 1, trig_in[trig_sel] is high at an edge, and no transfer is pending. The other trigger lines have no effect.
- R5: The sum of the holding value and the generator value, both taken at the acceptance edge, reaches dout at the third edge after acceptance. The transfer completes even if trig_en drops meanwhile.
- R6: The generator steps at the transfer edge, and only then. The next trigger uses the stepped value.
- R7: Noise comes from a 12-bit shift-left LFSR that shifts in bit11^bit5^bit3^bit0. It starts at 0xAAA and is never zero. Its output is ANDed with min(amp,11)+1 low-order ones.
- R8: The triangle count goes from 0 up to 2^(min(amp,11)+1)-1, then back down to 0, and repeats. Each step is by one.
- R9: A sum above 0xFFF is clamped to 0xFFF.
- R10: A trigger at any of the three edges that follow an acceptance is ignored.
- R11: After reset, dout and the holding value are 0, the noise register is 0xAAA and the triangle count is 0, counting up.
- R12: While trig_en is 1, dout changes only at transfer edges. Writes alone do not reach dout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_en | input | 1 | Trigger mode enable |
| trig_sel | input | 3 | Trigger line select |
| wave | input | 2 | Generator select |
| amp | input | 4 | Noise mask width / triangle amplitude |
| wr_en | input | 1 | Holding register write strobe |
| wr_fmt | input | 2 | Write alignment format |
| wr_data | input | 16 | Write data |
| trig_in | input | 8 | Trigger lines |
| dout | output | 12 | Output register |

## Verification
The bench targets the following corner cases:
- Triggers that repeat during the pending window. A design that accepted them would add extra transfers and extra generator steps.
- The noise sequence after reset, and its masking. If the generator stepped before the transfer, the very first noise transfer would already differ from 0xAAA.
- The triangle turnaround at the smallest amplitude, and sums near full scale. Getting these wrong shows up as skipped peaks or as wrapped, small outputs.
- Unselected trigger lines and writes made while triggering is enabled. A design that reacted to them would move dout outside a transfer edge.

// File: rtl/dac_wavegen.sv
module dac_wavegen #(
  parameter int W     = 12,
  parameter int NTRIG = 8,
  parameter int LAT   = 3,
  parameter logic [W-1:0] SEED = 12'hAAA
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trig_en,
  input  logic [$clog2(NTRIG)-1:0] trig_sel,
  input  logic [1:0]               wave,
  input  logic [3:0]               amp,
  input  logic                     wr_en,
  input  logic [1:0]               wr_fmt,
  input  logic [W+3:0]             wr_data,
  input  logic [NTRIG-1:0]         trig_in,
  output logic [W-1:0]             dout
);
  localparam int CW   = $clog2(LAT + 1);
  localparam int MAXA = W - 1;

  logic [W-1:0]  hold, lfsr, tri_v, pend, wval, gval, mask;
  logic [W:0]    one_sh, sum;
  logic [3:0]    a;
  logic          tri_up, acc, fb;
  logic [CW-1:0] cnt;

  assign a      = (amp > 4'(MAXA)) ? 4'(MAXA) : amp;
  assign one_sh = (W+1)'(1) << (a + 4'd1);
  assign mask   = W'(one_sh - 1'b1);
  assign fb     = lfsr[W-1] ^ lfsr[5] ^ lfsr[3] ^ lfsr[0];
  assign acc    = trig_en && trig_in[trig_sel] && (cnt == '0);
  assign sum    = {1'b0, hold} + {1'b0, gval};

  always_comb begin
    case (wr_fmt)
      2'b01:   wval = wr_data[W+3:4];
      2'b10:   wval = {wr_data[7:0], {(W-8){1'b0}}};
      default: wval = wr_data[W-1:0];
    endcase
  end

  always_comb begin
    if (wave[1])       gval = tri_v;
    else if (wave[0])  gval = lfsr & mask;
    else               gval = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold   <= '0;
      dout   <= '0;
      pend   <= '0;
      cnt    <= '0;
      lfsr   <= SEED;
      tri_v  <= '0;
      tri_up <= 1'b1;
    end else begin
      if (wr_en) hold <= wval;
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        dout <= pend;
        if (wave == 2'b01) lfsr <= {lfsr[W-2:0], fb};
        if (wave[1]) begin
          if (tri_up) begin
            if (tri_v >= mask) begin tri_v <= tri_v - 1'b1; tri_up <= 1'b0; end
            else tri_v <= tri_v + 1'b1;
          end else begin
            if (tri_v == '0) begin tri_v <= tri_v + 1'b1; tri_up <= 1'b1; end
            else tri_v <= tri_v - 1'b1;
          end
        end
      end else if (!trig_en) begin
        dout <= hold;
      end
      if (acc) begin
        pend <= sum[W] ? '1 : sum[W-1:0];
        cnt  <= CW'(LAT);
      end
    end
  end
endmodule

// File: rtl/dac_wavegen_chk.sv
module dac_wavegen_chk #(
  parameter int W = 12, parameter int NTRIG = 8, parameter int LAT = 3,
  parameter int CW = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     trig_en,
  input logic [$clog2(NTRIG)-1:0] trig_sel,
  input logic [NTRIG-1:0]         trig_in,
  input logic [1:0]               wave,
  input logic [W-1:0]             dout,
  input logic [W-1:0]             hold,
  input logic [W-1:0]             lfsr,
  input logic [W-1:0]             tri_v,
  input logic [CW-1:0]            cnt
);
  logic up;
  always_ff @(posedge clk) up <= rst_n;

  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n || !up)
    (cnt == '0 && trig_en && trig_in[trig_sel]) |=> (cnt == CW'(LAT)));
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n || !up)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  p_gen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n || !up)
    ($past(cnt) != CW'(1)) |-> ($stable(lfsr) && $stable(tri_v)));
  p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n || !up)
    lfsr != '0);
  p_tri_step_r8: assert property (@(posedge clk) disable iff (!rst_n || !up)
    ($past(cnt) == CW'(1) && $past(wave[1])) |->
      (tri_v == $past(tri_v) + 1'b1 || tri_v == $past(tri_v) - 1'b1));
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n || !up)
    ($past(trig_en) && $past(cnt) != CW'(1)) |-> $stable(dout));
  p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n || !up)
    (!$past(trig_en) && $past(cnt) != CW'(1)) |-> (dout == $past(hold)));
endmodule

bind dac_wavegen dac_wavegen_chk #(.W(W), .NTRIG(NTRIG), .LAT(LAT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .trig_sel(trig_sel),
  .trig_in(trig_in), .wave(wave), .dout(dout), .hold(hold), .lfsr(lfsr),
  .tri_v(tri_v), .cnt(cnt));

// File: tb/sim_dac_wavegen.sv
`timescale 1ns/1ps
module sim_dac_wavegen;
  logic        clk = 0, rst_n = 0, trig_en = 0, wr_en = 0;
  logic [2:0]  trig_sel = 0;
  logic [1:0]  wave = 0, wr_fmt = 0;
  logic [3:0]  amp = 0;
  logic [15:0] wr_data = 0;
  logic [7:0]  trig_in = 0;
  logic [11:0] dout;
  int n_chk = 0, n_bad = 0;
  string cur = "R11";

  always #2.5 clk = ~clk;

  dac_wavegen u0 (.clk(clk), .rst_n(rst_n), .trig_en(trig_en), .trig_sel(trig_sel),
    .wave(wave), .amp(amp), .wr_en(wr_en), .wr_fmt(wr_fmt), .wr_data(wr_data),
    .trig_in(trig_in), .dout(dout));

  // reference model built from the requirements
  logic [11:0] mh, md, mp, ml, mt;
  logic mu;
  int mc;
  function automatic [11:0] decode(input [1:0] f, input [15:0] d);
    case (f)
      2'b01: return d[15:4];
      2'b10: return {d[7:0], 4'h0};
      default: return d[11:0];
    endcase
  endfunction
  function automatic [11:0] msk(input [3:0] x);
    int k = (x > 11) ? 11 : x;
    return 12'((1 << (k + 1)) - 1);
  endfunction
  function automatic [11:0] satadd(input [11:0] x, input [11:0] y);
    int s = x + y;
    return (s > 4095) ? 12'hFFF : 12'(s);
  endfunction
  function automatic [11:0] genv(input [1:0] w, input [3:0] am, input [11:0] l, input [11:0] t);
    if (w[1]) return t;
    if (w[0]) return l & msk(am);
    return 12'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mh <= 0; md <= 0; mp <= 0; mc <= 0; ml <= 12'hAAA; mt <= 0; mu <= 1;
    end else begin
      if (wr_en) mh <= decode(wr_fmt, wr_data);
      if (mc != 0) mc <= mc - 1;
      if (mc == 1) begin
        md <= mp;
        if (wave == 2'b01) ml <= {ml[10:0], ml[11] ^ ml[5] ^ ml[3] ^ ml[0]};
        if (wave[1]) begin
          if (mu) begin
            if (mt >= msk(amp)) begin mt <= mt - 1; mu <= 0; end else mt <= mt + 1;
          end else begin
            if (mt == 0) begin mt <= 1; mu <= 1; end else mt <= mt - 1;
          end
        end
      end else if (!trig_en) md <= mh;
      if (trig_en && trig_in[trig_sel] && mc == 0) begin
        mp <= satadd(mh, genv(wave, amp, ml, mt));
        mc <= 3;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    n_chk++;
    if (dout !== md) begin
      n_bad++;
      $display("FAIL %s: dout=%h expected %h (model)", cur, dout, md);
    end
  end

  task automatic chk(input string r, input [11:0] exp);
    n_chk++;
    if (dout !== exp) begin
      n_bad++;
      $display("FAIL %s: dout=%h expected %h", r, dout, exp);
    end
  endtask
  task automatic wr(input [1:0] f, input [15:0] d);
    @(negedge clk); wr_en = 1; wr_fmt = f; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic fire(input string r, input [11:0] exp);
    @(negedge clk); trig_in = 8'(1 << trig_sel);
    @(negedge clk); trig_in = 0;
    @(negedge clk); @(negedge clk);
    chk(r, dout);
    @(negedge clk); chk(r, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); chk("R11", 12'h000);
    cur = "R3";
    @(negedge clk); wr_en = 1; wr_fmt = 0; wr_data = 16'h0123;
    @(negedge clk); wr_en = 0; chk("R3", 12'h000);
    @(negedge clk); chk("R3", 12'h123);
    cur = "R2";
    wr(2'b01, 16'hABC0); @(negedge clk); chk("R2", 12'hABC);
    wr(2'b10, 16'hFF5A); @(negedge clk); chk("R2", 12'h5A0);
    wr(2'b11, 16'hF321); @(negedge clk); chk("R2", 12'h321);
    cur = "R12";
    trig_en = 1; trig_sel = 5; wave = 0;
    wr(2'b00, 16'h0100);
    @(negedge clk); trig_in = 8'hDF; @(negedge clk); trig_in = 0;
    repeat (4) @(negedge clk);
    chk("R12", 12'h321); chk("R4", 12'h321);
    cur = "R5";
    fire("R5", 12'h100);
    cur = "R7";
    wave = 2'b01; amp = 11; wr(2'b00, 16'h0000);
    fire("R7", 12'hAAA);
    amp = 3; fire("R6", 12'h005);
    cur = "R10";
    amp = 11;
    @(negedge clk); trig_in = 8'h20;
    repeat (4) @(negedge clk);
    trig_in = 0; chk("R10", 12'hAAB);
    repeat (3) @(negedge clk); chk("R10", 12'hAAB);
    fire("R10", 12'h556);
    cur = "R9";
    wr(2'b00, 16'h0FFF); fire("R9", 12'hFFF);
    cur = "R8";
    wave = 2'b10; amp = 0; wr(2'b00, 16'h0010);
    fire("R8", 12'h010); fire("R8", 12'h011); fire("R8", 12'h010);
    wave = 2'b11; fire("R1", 12'h011);
    wave = 2'b00; fire("R1", 12'h010);
    cur = "R5";
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      trig_en = ($urandom % 8) != 0;
      if ($urandom % 16 == 0) trig_sel = 3'($urandom);
      if ($urandom % 32 == 0) wave = 2'($urandom);
      if ($urandom % 32 == 0) amp = 4'($urandom);
      wr_en = ($urandom % 6) == 0;
      wr_fmt = 2'($urandom);
      wr_data = ($urandom % 4 == 0) ? 16'hFFFF - 16'($urandom % 64) : 16'($urandom);
      trig_in = 8'($urandom & $urandom);
    end
    @(negedge clk); trig_in = 0; wr_en = 0;
    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule